// File: doc/BRIEF.md
# Integer ALU with Shifter, Flag Generation and Condition Evaluation

This block is the arithmetic stage of a small 32-bit RISC core. It is purely combinational. Each cycle it takes an operation code, two operands, the condition field of the instruction being executed and the current condition flags. It returns the operation's result, the flag word that the flag register should hold next, a result write-enable and an execute-enable.

The operations are add, subtract, compare, bitwise AND/OR/XOR and three barrel shifts: left, logical right and arithmetic right. For shifts, operand A is the value being shifted and operand B is the shift count. A count of exactly 32 gives a defined result and a defined carry. Any count above 32 behaves as a count of 32.

Every instruction carries a condition. When the condition does not hold against the incoming flags, the instruction changes nothing: the result is not written and the flag output repeats the incoming flags.

Top module: `alu_core`

## Requirements
- R1: ADD (op 0) outputs A+B mod 2^32. C is the unsigned carry out. V is set when two operands of the same sign give a result of the other sign, for example 0x7FFFFFFF+1 sets V and 0xFFFFFFFF+1 sets C.
- R2: SUB (op 1) outputs A-B mod 2^32. C is set on a borrow, meaning A < B unsigned. V is signed overflow, for example 0x80000000-1 sets V and 0-1 sets C.
- R3: CMP (op 2) produces the same flags as SUB and holds the result write-enable low.
- R4: AND (op 3), OR (op 4) and XOR (op 5) output the bitwise result and clear C and V.
- R5: The flag word is {V,N,C,Z} on bits 3..0. Z is set when the result is zero, and N is result bit 31.
- R6: LSR (op 7) and ASR (op 8) shift right, filling with zero or with the sign bit. C is the last bit shifted out, so 1 shifted right by 1 sets C for both, and -4 ASR 2 gives -1. A count of 0 returns A unchanged with C clear.
- R7: LSL (op 6) shifts left, filling with zero. C is the last bit shifted out of bit 31, and a count of 0 leaves C clear.
- R8: A count of 32 or more shifts all bits out. LSL and LSR give 0 with C equal to bit 0 or bit 31 of A, and ASR gives 32 copies of the sign bit with C equal to that sign. For example, 0xFFFFFFFF by 32 gives 0 with Z and C set for LSL and LSR, and 0xFFFFFFFF with N and C set for ASR.
- R9: Any shift sets V exactly when bit 31 of the result differs from bit 31 of A.
- R10: The condition field encodes 0=always, 1=Z, 2=NZ, 3=LT (N xor V), 4=GE (not LT), 5=GT (not Z and GE), 6=C and 7=V. The execute-enable is high exactly when the selected condition holds.
- R11: When the execute-enable is low, the result write-enable is low and the flag output equals the flag input.
- R12: Op codes 9 to 15 do nothing. The result is 0, the write-enable is low and the flag output equals the flag input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A; the value shifted by shift operations |
| b_i | input | 32 | Operand B; the shift count for shift operations |
| cond_i | input | 3 | Condition field of the instruction |
| flags_i | input | 4 | Current flags {V,N,C,Z} |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | Next value of the flag register |
| res_we_o | output | 1 | Result write-enable |
| exec_o | output | 1 | Condition holds; the instruction takes effect |

## Verification
The assertions assume only that every input is a settled 2-state value whenever the combinational checks evaluate. Apart from that, they hold for any op code, any operand pair and any flag word, including op codes outside the defined set. To stay within that assumption, the stimulus changes inputs only just after a rising edge and compares the outputs at the falling edge. The stimulus also concentrates on sign-boundary operands and on shift counts near 0, 31, 32 and above 32.

// File: rtl/alu_pkg.sv
// Shared types for the ALU: operation codes, condition codes, flag layout.
// Assumes op and condition codes are fixed encodings decoded by the core.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_LSL = 4'd6,
        OP_LSR = 4'd7,
        OP_ASR = 4'd8
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_Z      = 3'd1,
        CC_NZ     = 3'd2,
        CC_LT     = 3'd3,
        CC_GE     = 3'd4,
        CC_GT     = 3'd5,
        CC_C      = 3'd6,
        CC_V      = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LOGIC = 2'd1,
        SH_ARITH = 2'd2
    } shift_e;

    // Flag word, bit 3 down to bit 0.
    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor with carry (borrow on subtract) and signed overflow.
// Assumes: sub selects A-B, otherwise A+B; borrow is reported as carry.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0]   wide;
    logic [W-1:0] b_eff;

    // Compute the widened sum or difference and its signed overflow.
    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
        b_eff = sub ? ~b : b;
        sum   = wide[W-1:0];
        carry = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // R2: a borrow flags exactly the unsigned A < B case.
    always_comb begin
        if (sub) a_r2_borrow_is_less: assert (carry == (a < b));
    end

endmodule

// File: rtl/alu_shifter.sv
// Barrel shifter: left, logical right, arithmetic right. Counts above W
// saturate to W. Carry is the last bit shifted out; sign change raises ovf.
// Assumes W is a power of two.
module alu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   count,
    input  alu_pkg::shift_e kind,
    output logic [W-1:0]   res,
    output logic           carry,
    output logic           ovf
);
    import alu_pkg::*;

    localparam int AW = $clog2(W) + 1;
    localparam logic [W-1:0] CNT_MAX = W'(W);

    logic [AW-1:0] amt;
    logic          fill;
    logic [2*W:0]  rwide;
    logic [W:0]    lwide;

    // Saturate the shift count to at most W positions.
    always_comb begin
        if (count > CNT_MAX) amt = CNT_MAX[AW-1:0];
        else                 amt = count[AW-1:0];
    end

    // Shift with one guard bit on the outgoing side to capture the carry.
    always_comb begin
        fill  = (kind == SH_ARITH) && a[W-1];
        rwide = {{W{fill}}, a, 1'b0} >> amt;
        lwide = {1'b0, a} << amt;
        if (kind == SH_LEFT) begin
            res   = lwide[W-1:0];
            carry = lwide[W];
        end else begin
            res   = rwide[W:1];
            carry = rwide[0];
        end
        ovf = res[W-1] != a[W-1];
    end

    // R6/R7: a zero count passes A through with carry clear.
    always_comb begin
        if (count == '0) a_r6_zero_count_identity: assert (res == a && !carry);
        if (count >= CNT_MAX && kind != SH_ARITH)
            a_r8_full_shift_clears: assert (res == '0);
        if (count >= CNT_MAX && kind == SH_ARITH)
            a_r8_full_shift_sign: assert (res == {W{a[W-1]}} && carry == a[W-1]);
    end

endmodule

// File: rtl/alu_cond.sv
// Condition evaluator: decides whether a predicated instruction executes.
// Assumes the flag word layout from alu_pkg.
module alu_cond (
    input  alu_pkg::cond_e cond,
    input  alu_pkg::flags_t fl,
    output logic           take
);
    import alu_pkg::*;

    logic lt;

    // Select the predicate named by the condition field.
    always_comb begin
        lt = fl.n ^ fl.v;
        unique case (cond)
            CC_ALWAYS: take = 1'b1;
            CC_Z:      take = fl.z;
            CC_NZ:     take = !fl.z;
            CC_LT:     take = lt;
            CC_GE:     take = !lt;
            CC_GT:     take = !fl.z && !lt;
            CC_C:      take = fl.c;
            CC_V:      take = fl.v;
            default:   take = 1'b1;
        endcase
    end

    // R10: GT can only hold when GE-style ordering holds and Z is clear.
    always_comb begin
        if (cond == CC_GT && take) a_r10_gt_implies_nz: assert (!fl.z && (fl.n == fl.v));
    end

endmodule

// File: rtl/alu_core.sv
// Top of the ALU: decodes the operation, selects adder/shifter/logic result,
// forms the next flag word and gates writes by the instruction's condition.
// Assumes inputs are settled for the whole cycle; purely combinational.
module alu_core #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   cond_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] result_o,
    output logic [3:0]   flags_o,
    output logic         res_we_o,
    output logic         exec_o
);
    import alu_pkg::*;

    alu_op_e      op;
    flags_t       fl_in;
    flags_t       fl_new;
    logic         op_valid;
    logic         op_writes;
    logic         op_arith;
    logic         op_shift;
    logic         is_sub;
    shift_e       sh_kind;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_v;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic         sh_v;
    logic         take;

    assign op    = alu_op_e'(op_i);
    assign fl_in = flags_t'(flags_i);

    // Decode the operation into datapath controls.
    always_comb begin
        op_valid  = 1'b1;
        op_writes = 1'b1;
        op_arith  = 1'b0;
        op_shift  = 1'b0;
        is_sub    = 1'b0;
        sh_kind   = SH_LEFT;
        case (op)
            OP_ADD: op_arith = 1'b1;
            OP_SUB: begin op_arith = 1'b1; is_sub = 1'b1; end
            OP_CMP: begin op_arith = 1'b1; is_sub = 1'b1; op_writes = 1'b0; end
            OP_AND, OP_OR, OP_XOR: ;
            OP_LSL: op_shift = 1'b1;
            OP_LSR: begin op_shift = 1'b1; sh_kind = SH_LOGIC; end
            OP_ASR: begin op_shift = 1'b1; sh_kind = SH_ARITH; end
            default: begin op_valid = 1'b0; op_writes = 1'b0; end
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(a_i), .b(b_i), .sub(is_sub),
        .sum(as_sum), .carry(as_c), .ovf(as_v)
    );

    alu_shifter #(.W(W)) u_shift (
        .a(a_i), .count(b_i), .kind(sh_kind),
        .res(sh_res), .carry(sh_c), .ovf(sh_v)
    );

    alu_cond u_cond (
        .cond(cond_e'(cond_i)), .fl(fl_in), .take(take)
    );

    // Select the result and build the new flag word.
    always_comb begin
        result_o = '0;
        fl_new   = '0;
        if (op_arith) begin
            result_o = as_sum;
            fl_new.c = as_c;
            fl_new.v = as_v;
        end else if (op_shift) begin
            result_o = sh_res;
            fl_new.c = sh_c;
            fl_new.v = sh_v;
        end else if (op == OP_AND) begin
            result_o = a_i & b_i;
        end else if (op == OP_OR) begin
            result_o = a_i | b_i;
        end else if (op == OP_XOR) begin
            result_o = a_i ^ b_i;
        end
        fl_new.z = (result_o == '0);
        fl_new.n = result_o[W-1];
    end

    // Gate writes and flag updates by the condition.
    always_comb begin
        exec_o   = take;
        res_we_o = take && op_writes;
        flags_o  = (take && op_valid) ? fl_new : fl_in;
    end

    // Checks relating the decoder, datapath and gating.
    always_comb begin
        if (op == OP_CMP) a_r3_cmp_no_write: assert (!res_we_o);
        if (!exec_o) a_r11_skip_holds_flags: assert (!res_we_o && flags_o == flags_i);
        if (op_i > 4'd8) a_r12_undef_inert: assert (!res_we_o && flags_o == flags_i && result_o == '0);
        if (exec_o && (op == OP_AND || op == OP_OR || op == OP_XOR))
            a_r4_logic_clears_cv: assert (flags_o[1] == 1'b0 && flags_o[3] == 1'b0);
        if (exec_o && op_valid)
            a_r5_zero_tracks_result: assert (flags_o[0] == (result_o == '0) && flags_o[2] == result_o[W-1]);
    end

endmodule

// File: tb/sim_alu_core.sv
// Bench for alu_core: behavioural reference model compared every clock.
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [2:0]  cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;
    logic        res_we_o;
    logic        exec_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .cond_i(cond_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o), .res_we_o(res_we_o), .exec_o(exec_o)
    );

    // Reference model, written from the requirements.
    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [2:0] cc,
                                  input logic [3:0] fin,
                                  output logic [31:0] r, output logic [3:0] fo,
                                  output logic we, output logic ex);
        longint sa, sb, s;
        logic c, v, take, writes, valid;
        int n;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r = 0; c = 0; v = 0; writes = 1; valid = 1;
        case (op)
            4'd0: begin s = sa + sb; r = a + b; c = ({1'b0, a} + {1'b0, b}) > 33'h0FFFFFFFF;
                        v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'd1, 4'd2: begin s = sa - sb; r = a - b; c = a < b;
                        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                        if (op == 4'd2) writes = 0; end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6, 4'd7, 4'd8: begin
                n = (b > 32) ? 32 : int'(b);
                r = a;
                for (int i = 0; i < n; i++) begin
                    if (op == 4'd6) begin c = r[31]; r = r << 1; end
                    else if (op == 4'd7) begin c = r[0]; r = r >> 1; end
                    else begin c = r[0]; r = {r[31], r[31:1]}; end
                end
                v = r[31] != a[31];
            end
            default: begin valid = 0; writes = 0; end
        endcase
        case (cc)
            3'd0: take = 1;
            3'd1: take = fin[0];
            3'd2: take = !fin[0];
            3'd3: take = fin[2] != fin[3];
            3'd4: take = fin[2] == fin[3];
            3'd5: take = !fin[0] && (fin[2] == fin[3]);
            3'd6: take = fin[1];
            default: take = fin[3];
        endcase
        ex = take;
        we = take && writes;
        fo = (take && valid) ? {v, r[31], c, r == 0} : fin;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [31:0] b);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6: return (b >= 32) ? "R8" : "R7";
            4'd7, 4'd8: return (b >= 32) ? "R8" : "R6";
            default: return "R12";
        endcase
    endfunction

    // Apply one vector after a rising edge, compare at the falling edge.
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] cc, input logic [3:0] fin, input string tag);
        logic [31:0] er; logic [3:0] ef; logic ew, ee;
        @(posedge clk);
        op_i = op; a_i = a; b_i = b; cond_i = cc; flags_i = fin;
        @(negedge clk);
        model(op, a, b, cc, fin, er, ef, ew, ee);
        n_checks++;
        if (result_o !== er || flags_o !== ef || res_we_o !== ew || exec_o !== ee) begin
            n_errors++;
            $display("FAIL %s: op=%0d a=%h b=%h cc=%0d fl=%h actual r=%h f=%h we=%b ex=%b expected r=%h f=%h we=%b ex=%b",
                     tag, op, a, b, cc, fin, result_o, flags_o, res_we_o, exec_o, er, ef, ew, ee);
        end
    endtask

    // Check one specific expected flag word (pins down field positions, R5).
    task automatic expect_flags(input logic [3:0] ef, input string tag);
        n_checks++;
        if (flags_o !== ef) begin
            n_errors++;
            $display("FAIL %s: flags actual=%h expected=%h", tag, flags_o, ef);
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFFFFFF;
            3: return 32'h80000000;
            4: return 32'hFFFFFFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        // Reset state: all-zero inputs give ADD 0+0 with only Z set (R5).
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_flags(4'b0001, "R5 reset");
        // R1
        apply(4'd0, 32'h7FFFFFFF, 32'h1, 3'd0, 4'h0, "R1 max+1");
        expect_flags(4'b1100, "R1 V and N");
        apply(4'd0, 32'hFFFFFFFF, 32'h1, 3'd0, 4'h0, "R1 carry");
        expect_flags(4'b0011, "R1 C and Z");
        // R2
        apply(4'd1, 32'h80000000, 32'h1, 3'd0, 4'h0, "R2 min-1");
        expect_flags(4'b1000, "R2 V only");
        apply(4'd1, 32'h0, 32'h1, 3'd0, 4'h0, "R2 borrow");
        // R3
        apply(4'd2, 32'h0, 32'h1, 3'd0, 4'h0, "R3 cmp borrow");
        apply(4'd2, 32'h5, 32'h5, 3'd0, 4'hF, "R3 cmp equal");
        // R4
        apply(4'd3, 32'hF0F0F0F0, 32'hFF00FF00, 3'd0, 4'hA, "R4 and");
        apply(4'd4, 32'h80000000, 32'h1, 3'd0, 4'hF, "R4 or");
        apply(4'd5, 32'h1234, 32'h1234, 3'd0, 4'hE, "R4 xor zero");
        // R6
        apply(4'd7, 32'h1, 32'd1, 3'd0, 4'h0, "R6 lsr carry");
        apply(4'd8, 32'h1, 32'd1, 3'd0, 4'h0, "R6 asr carry");
        apply(4'd8, 32'hFFFFFFFC, 32'd2, 3'd0, 4'h0, "R6 asr -4");
        apply(4'd8, 32'hFFFFFFFF, 32'd0, 3'd0, 4'h0, "R6 zero count");
        // R7
        apply(4'd6, 32'hC0000001, 32'd2, 3'd0, 4'h0, "R7 lsl carry");
        apply(4'd6, 32'hFFFFFFFF, 32'd0, 3'd0, 4'h0, "R7 zero count");
        // R8
        apply(4'd7, 32'hFFFFFFFF, 32'd32, 3'd0, 4'h0, "R8 lsr 32");
        expect_flags(4'b1011, "R8 lsr 32 flags");
        apply(4'd6, 32'hFFFFFFFF, 32'd32, 3'd0, 4'h0, "R8 lsl 32");
        apply(4'd8, 32'hFFFFFFFF, 32'd32, 3'd0, 4'h0, "R8 asr 32");
        expect_flags(4'b0110, "R8 asr 32 flags");
        apply(4'd6, 32'h00000001, 32'd33, 3'd0, 4'h0, "R8 lsl sat");
        apply(4'd7, 32'h80000000, 32'hFFFFFFFF, 3'd0, 4'h0, "R8 lsr sat");
        // R9
        apply(4'd7, 32'h80000000, 32'd1, 3'd0, 4'h0, "R9 lsr sign");
        apply(4'd6, 32'h40000000, 32'd1, 3'd0, 4'h0, "R9 lsl into sign");
        apply(4'd6, 32'h80000000, 32'd1, 3'd0, 4'h0, "R9 lsl out of sign");
        // R10 and R11: every condition against every flag word
        for (int cc = 0; cc < 8; cc++)
            for (int f = 0; f < 16; f++)
                apply(4'd0, 32'h3, 32'h4, 3'(cc), 4'(f), (f == 0) ? "R10" : "R11");
        // R12
        for (int o = 9; o < 16; o++)
            apply(4'(o), 32'hDEADBEEF, 32'h1, 3'd0, 4'h5, "R12");
        // Mixed random vectors
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] op; logic [31:0] b;
            op = 4'($urandom_range(0, 9));
            b  = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 40)) : pick();
            apply(op, pick(), b, 3'($urandom_range(0, 7)), 4'($urandom), tag_of(op, b));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule